// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from sixteen external pins and a handful of on-chip lines, and reduces them to a single interrupt output toward a processor. Each source has a configuration word. The word holds a disable bit, a read-only busy flag, pin polarity, a level/edge selection, a 4-bit priority and an 8-bit vector. Software runs a word-addressed register port with plain write and read strobes. A read of the acknowledge address returns the vector of the winning source and moves that source into service. A write to the end-of-service address retires the interrupt being handled. A threshold register holds back everything at or below its level.

Service nests. A source already in service blocks every source whose priority is equal or lower, until it is retired. Higher-priority sources can still preempt it. When nothing can be presented, the acknowledge read returns 0xFF and changes no state. The register port has no back-pressure: a strobe is taken on the clock edge where it is high. Read data is registered and valid on the cycle after the read strobe.

Top module: `pic_top`

## Requirements
- R1: After reset every source word reads 0x80800000 (disabled, polarity 1, edge mode, priority 0, vector 0), the threshold reads 0, `irq_out` is low and an acknowledge read returns 0xFF.
- R2: Source word layout: bit 31 disable, bit 30 busy (read-only, set while the source requests or is in service), bit 23 polarity, bit 22 sense (1 level, 0 edge), bits 19:16 priority (15 highest), bits 7:0 vector. Other bits read 0. Source n sits at address n (0..15 external, 16..21 internal), acknowledge at 48, end-of-service at 49, threshold at 50.
- R3: A disabled source is never presented. An edge seen while disabled is not latched. A write always updates the disable bit.
- R4: An external level source requests while its pin equals its polarity bit.
- R5: An external edge source latches a request on a rising pin (polarity 1) or a falling pin (polarity 0). The latch is cleared when that source is acknowledged.
- R6: Internal sources request while their line is high, whatever their polarity and sense bits hold.
- R7: An acknowledge read returns the vector of the presentable source with the highest priority. On equal priority the lowest address wins. That source enters service.
- R8: With nothing presentable, an acknowledge read returns 0xFF and changes no state.
- R9: A source is presentable only if its priority is strictly above the threshold. The threshold stores the low 4 bits of a write and reads them back.
- R10: While sources are in service, only a source whose priority is strictly above the highest in-service priority is presentable.
- R11: Any write to the end-of-service address retires the in-service source of highest priority (lowest address on ties). With none in service it has no effect.
- R12: Writes to polarity, sense, priority and vector are ignored while the busy flag is set.
- R13: `irq_out` is high exactly when some source is presentable.
- R14: When a new edge arrives on a source in the same cycle that source is acknowledged, the new request is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_req | input | 16 | External request pins |
| int_req | input | 6 | Internal request lines |
| reg_addr | input | 6 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe (an acknowledge read has side effects) |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
Two functions can collide on one edge-mode source: the clear done by an acknowledge read, and the latch of a fresh edge. The bench brings on a second rising edge in the very cycle the acknowledge strobe is sampled. It then retires the first service and expects `irq_out` to rise again and a second acknowledge to return the same vector. Once that is drained, a third acknowledge must give 0xFF. The sweeps over source index, polarity, threshold and priority take their expected values from the requirement formulas.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int WORD_W   = 32;
  localparam int PRIO_W   = 4;
  localparam int VEC_W    = 8;
  localparam int BIT_OFF  = 31;
  localparam int BIT_BUSY = 30;
  localparam int BIT_POL  = 23;
  localparam int BIT_SNS  = 22;
  localparam int PRIO_LSB = 16;
  localparam logic [VEC_W-1:0] NO_VECTOR = 8'hFF;

  typedef struct packed {
    logic              off;
    logic              pol;
    logic              sns;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } src_cfg_t;
endpackage

// File: rtl/pic_pick.sv
module pic_pick
  import pic_pkg::*;
#(
  parameter int N     = 22,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]             cand,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  output logic                     found,
  output logic [IDX_W-1:0]         idx,
  output logic [PRIO_W-1:0]        best
);
  // strict compare in ascending order keeps the lowest index on ties
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || prio[i] > best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = prio[i];
      end
    end
  end
endmodule

// File: rtl/pic_src.sv
module pic_src
  import pic_pkg::*;
#(
  parameter bit EXTERNAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_in,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ack_take,
  input  logic              eoi_take,
  output src_cfg_t          cfg,
  output logic              requesting,
  output logic              in_svc,
  output logic              busy
);
  logic act_now, prev_act, level_mode, edge_hit, edge_lat;

  assign act_now    = EXTERNAL ? (cfg.pol ? req_in : ~req_in) : req_in;
  assign level_mode = EXTERNAL ? cfg.sns : 1'b1;
  assign edge_hit   = act_now & ~prev_act & ~cfg.off & ~level_mode;
  assign requesting = level_mode ? act_now : edge_lat;
  assign busy       = requesting | in_svc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_act <= 1'b0;
      edge_lat <= 1'b0;
      in_svc   <= 1'b0;
      cfg      <= '{off: 1'b1, pol: 1'b1, sns: 1'b0, prio: '0, vec: '0};
    end else begin
      prev_act <= act_now;
      if (edge_hit)                    edge_lat <= 1'b1;
      else if (ack_take || level_mode) edge_lat <= 1'b0;
      if (ack_take)      in_svc <= 1'b1;
      else if (eoi_take) in_svc <= 1'b0;
      if (cfg_we) begin
        cfg.off <= wdata[BIT_OFF];
        if (!busy) begin
          cfg.pol  <= wdata[BIT_POL];
          cfg.sns  <= wdata[BIT_SNS];
          cfg.prio <= wdata[PRIO_LSB +: PRIO_W];
          cfg.vec  <= wdata[VEC_W-1:0];
        end
      end
    end
  end

  p_ack_enters_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> in_svc);
  p_locked_fields_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && busy) |=> ($stable(cfg.prio) && $stable(cfg.vec) && $stable(cfg.pol) && $stable(cfg.sns)));
  p_disable_applied_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg.off == $past(wdata[BIT_OFF])));
  p_edge_kept_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && ack_take) |=> requesting);
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int N_EXT    = 16,
  parameter int N_INT    = 6,
  parameter int ADDR_W   = 6,
  parameter int ACK_ADDR = 48,
  parameter int EOI_ADDR = 49,
  parameter int THR_ADDR = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_req,
  input  logic [N_INT-1:0]  int_req,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq_out
);
  localparam int NSRC  = N_EXT + N_INT;
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]             req_vec, requesting, in_svc, busy, present, ack_take, eoi_take;
  logic [NSRC-1:0][PRIO_W-1:0] prio_arr;
  logic [NSRC-1:0][VEC_W-1:0]  vec_arr;
  logic [NSRC-1:0][WORD_W-1:0] word_arr;
  logic [PRIO_W-1:0]           thr, best_p, best_s;
  logic [IDX_W-1:0]            idx_p, idx_s;
  logic                        found_p, found_s, ack_rd, eoi_wr;

  assign req_vec = {int_req, ext_req};
  assign ack_rd  = reg_rd && (reg_addr == ADDR_W'(ACK_ADDR));
  assign eoi_wr  = reg_wr && (reg_addr == ADDR_W'(EOI_ADDR));

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    src_cfg_t cfg;
    pic_src #(.EXTERNAL(g < N_EXT)) u_src (
      .clk(clk), .rst_n(rst_n), .req_in(req_vec[g]),
      .cfg_we(reg_wr && (reg_addr == ADDR_W'(g))), .wdata(reg_wdata),
      .ack_take(ack_take[g]), .eoi_take(eoi_take[g]), .cfg(cfg),
      .requesting(requesting[g]), .in_svc(in_svc[g]), .busy(busy[g])
    );
    assign prio_arr[g] = cfg.prio;
    assign vec_arr[g]  = cfg.vec;
    assign word_arr[g] = {cfg.off, busy[g], 6'b0, cfg.pol, cfg.sns, 2'b0, cfg.prio, 8'b0, cfg.vec};
    assign present[g]  = requesting[g] & ~cfg.off & ~in_svc[g] & (cfg.prio > thr)
                         & (!found_s || cfg.prio > best_s);
    assign ack_take[g] = ack_rd && found_p && (idx_p == IDX_W'(g));
    assign eoi_take[g] = eoi_wr && found_s && (idx_s == IDX_W'(g));
  end

  pic_pick #(.N(NSRC)) u_pick_req (
    .cand(present), .prio(prio_arr), .found(found_p), .idx(idx_p), .best(best_p));
  pic_pick #(.N(NSRC)) u_pick_svc (
    .cand(in_svc), .prio(prio_arr), .found(found_s), .idx(idx_s), .best(best_s));

  assign irq_out = found_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr       <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && (reg_addr == ADDR_W'(THR_ADDR))) thr <= reg_wdata[PRIO_W-1:0];
      if (reg_rd) begin
        if (32'(reg_addr) < NSRC)
          reg_rdata <= word_arr[reg_addr[IDX_W-1:0]];
        else if (ack_rd)
          reg_rdata <= WORD_W'(found_p ? vec_arr[idx_p] : NO_VECTOR);
        else if (reg_addr == ADDR_W'(THR_ADDR))
          reg_rdata <= WORD_W'(thr);
        else
          reg_rdata <= '0;
      end
    end
  end

  p_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !irq_out) |=> (reg_rdata == WORD_W'(NO_VECTOR)));
  p_single_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_take));
  p_threshold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (best_p > thr));
  p_nesting_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && found_s) |-> (best_p > best_s));
  p_eoi_retires_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && found_s && !ack_rd) |=> ($countones(in_svc) == $past($countones(in_svc)) - 1));
endmodule

// File: tb/sim_pic_top.sv
`timescale 1ns/1ps
module sim_pic_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] ext_req = '0;
  logic [5:0]  int_req = '0;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq_out;
  int checks = 0, errors = 0;
  localparam int ACK = 48, EOI = 49, THR = 50;

  always #2.5 clk = ~clk;

  pic_top u0 (.clk(clk), .rst_n(rst_n), .ext_req(ext_req), .int_req(int_req),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq_out(irq_out));

  function automatic logic [31:0] cfgw(logic off, logic pol, logic sns, logic [3:0] p, logic [7:0] v);
    return {off, 1'b0, 6'b0, pol, sns, 2'b0, p, 8'b0, v};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask
  task automatic tick(); @(negedge clk); endtask
  task automatic wr(int a, logic [31:0] d);
    reg_addr = 6'(a); reg_wdata = d; reg_wr = 1'b1; @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic rd(int a, output logic [31:0] d);
    reg_addr = 6'(a); reg_rd = 1'b1; @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state, R2 layout
    chk("R1 irq", 32'(irq_out), 0);
    rd(0, d);  chk("R1 src0", d, 32'h8080_0000);
    rd(21, d); chk("R1 src21", d, 32'h8080_0000);
    rd(THR, d); chk("R1 thr", d, 0);
    rd(ACK, d); chk("R1 ack", d, 32'hFF);
    wr(3, 32'h80C9_005A); rd(3, d); chk("R2 readback", d, 32'h80C9_005A);
    wr(3, 32'h8080_0000);

    // R4 level sweep, R7 ack, R13 irq
    for (int i = 0; i < 16; i++) begin
      for (int pol = 0; pol < 2; pol++) begin
        logic [3:0] p; logic [7:0] v;
        p = 4'((i % 15) + 1); v = 8'(8'h40 + i);
        ext_req[i] = ~pol[0];
        wr(i, cfgw(0, pol[0], 1, p, v)); tick();
        chk("R4 idle", 32'(irq_out), 0);
        ext_req[i] = pol[0]; tick();
        chk("R13 level irq", 32'(irq_out), 1);
        rd(ACK, d); chk("R7 level vec", d, 32'(v));
        chk("R10 own level", 32'(irq_out), 0);
        ext_req[i] = ~pol[0]; wr(EOI, 0);
        rd(i, d); chk("R4 idle word", d, cfgw(0, pol[0], 1, p, v));
        wr(i, 32'h8080_0000); ext_req[i] = 1'b0; tick();
      end
    end

    // R5 edge sweep
    for (int i = 0; i < 16; i++) begin
      for (int pol = 0; pol < 2; pol++) begin
        logic [7:0] v; v = 8'(8'h80 + i);
        ext_req[i] = ~pol[0]; tick();
        wr(i, cfgw(0, pol[0], 0, 5, v)); tick();
        chk("R5 idle", 32'(irq_out), 0);
        ext_req[i] = pol[0]; tick();
        ext_req[i] = ~pol[0]; tick();
        chk("R5 latched", 32'(irq_out), 1);
        rd(ACK, d); chk("R5 vec", d, 32'(v));
        wr(EOI, 0);
        chk("R5 cleared", 32'(irq_out), 0);
        wr(i, 32'h8080_0000); ext_req[i] = 1'b0; tick();
      end
    end

    // R6 internal sources ignore polarity and sense
    for (int j = 0; j < 6; j++) begin
      logic [7:0] v; v = 8'(8'h20 + j);
      wr(16 + j, cfgw(0, j[0], j[1], 7, v)); tick();
      chk("R6 low", 32'(irq_out), 0);
      int_req[j] = 1'b1; tick();
      chk("R6 high", 32'(irq_out), 1);
      rd(ACK, d); chk("R6 vec", d, 32'(v));
      int_req[j] = 1'b0; wr(EOI, 0);
      wr(16 + j, 32'h8080_0000);
    end

    // R3 disable behaviour
    wr(10, cfgw(1, 1, 0, 5, 8'hA0));
    ext_req[10] = 1; tick(); ext_req[10] = 0; tick();
    wr(10, cfgw(0, 1, 0, 5, 8'hA0)); tick();
    chk("R3 edge while off", 32'(irq_out), 0);
    wr(11, cfgw(1, 1, 1, 5, 8'hB0)); ext_req[11] = 1; tick();
    chk("R3 level while off", 32'(irq_out), 0);
    wr(11, cfgw(0, 1, 1, 5, 8'hB0));
    chk("R3 enabled", 32'(irq_out), 1);
    rd(ACK, d); chk("R3 vec", d, 32'hB0);
    ext_req[11] = 0; wr(EOI, 0);
    wr(10, 32'h8080_0000); wr(11, 32'h8080_0000);

    // R12 locked fields
    wr(9, cfgw(0, 1, 1, 4, 8'h99)); ext_req[9] = 1; tick();
    rd(ACK, d);
    wr(9, cfgw(0, 1, 1, 12, 8'h11)); rd(9, d); chk("R12 locked", d, 32'h40C4_0099);
    wr(9, cfgw(1, 1, 1, 12, 8'h11)); rd(9, d); chk("R12 off bit", d, 32'hC0C4_0099);
    ext_req[9] = 0; wr(EOI, 0);
    rd(9, d); chk("R12 idle", d, 32'h80C4_0099);
    wr(9, cfgw(1, 1, 1, 12, 8'h11)); rd(9, d); chk("R12 free", d, 32'h80CC_0011);
    wr(9, 32'h8080_0000);

    // R7 ties, R10 blocking, R8 spurious
    wr(2, cfgw(0, 1, 1, 6, 8'h12)); wr(5, cfgw(0, 1, 1, 6, 8'h15));
    wr(17, cfgw(0, 0, 0, 4, 8'h21));
    ext_req[2] = 1; ext_req[5] = 1; int_req[1] = 1; tick();
    rd(ACK, d); chk("R7 tie low index", d, 32'h12);
    chk("R10 equal blocked", 32'(irq_out), 0);
    ext_req[2] = 0; wr(EOI, 0);
    rd(ACK, d); chk("R7 second", d, 32'h15);
    ext_req[5] = 0; wr(EOI, 0);
    rd(ACK, d); chk("R7 lowest prio", d, 32'h21);
    int_req[1] = 0; wr(EOI, 0);
    rd(ACK, d); chk("R8 spurious", d, 32'hFF);
    chk("R8 no change", 32'(irq_out), 0);
    wr(2, 32'h8080_0000); wr(5, 32'h8080_0000); wr(17, 32'h8080_0000);

    // R10 preemption, R11 retire order
    wr(6, cfgw(0, 1, 1, 3, 8'h33)); wr(7, cfgw(0, 1, 1, 8, 8'h77));
    ext_req[6] = 1; tick();
    rd(ACK, d); chk("R7 low first", d, 32'h33);
    ext_req[7] = 1; tick();
    chk("R10 preempt irq", 32'(irq_out), 1);
    rd(ACK, d); chk("R10 preempt vec", d, 32'h77);
    ext_req[6] = 0; ext_req[7] = 0; wr(EOI, 0);
    rd(7, d); chk("R11 high retired", d, 32'h00C8_0077);
    rd(6, d); chk("R11 low kept", d, 32'h40C3_0033);
    wr(EOI, 0); rd(6, d); chk("R11 low retired", d, 32'h00C3_0033);
    wr(EOI, 0); rd(6, d); chk("R11 empty eoi", d, 32'h00C3_0033);
    chk("R11 irq", 32'(irq_out), 0);
    wr(6, 32'h8080_0000); wr(7, 32'h8080_0000);

    // R9 threshold sweep
    for (int c = 0; c < 16; c++) begin
      wr(THR, 32'(c));
      for (int p = 1; p < 16; p++) begin
        wr(0, cfgw(0, 1, 1, 4'(p), 8'h01));
        ext_req[0] = 1; tick();
        chk("R9 threshold", 32'(irq_out), 32'(p > c));
        ext_req[0] = 0; tick();
      end
    end
    wr(THR, 32'h1F); rd(THR, d); chk("R9 thr width", d, 32'hF);
    wr(THR, 0); wr(0, 32'h8080_0000);

    // R14 new edge coincident with acknowledge
    wr(4, cfgw(0, 1, 0, 5, 8'h44));
    ext_req[4] = 1; tick(); ext_req[4] = 0; tick();
    reg_addr = 6'(ACK); reg_rd = 1; ext_req[4] = 1; tick(); reg_rd = 0;
    chk("R14 first vec", reg_rdata, 32'h44);
    ext_req[4] = 0; tick();
    chk("R14 in service", 32'(irq_out), 0);
    wr(EOI, 0);
    chk("R14 kept irq", 32'(irq_out), 1);
    rd(ACK, d); chk("R14 second vec", d, 32'h44);
    wr(EOI, 0);
    rd(ACK, d); chk("R14 drained", d, 32'hFF);
    wr(4, 32'h8080_0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule